// File: doc/BRIEF.md
# Atomic Memory Instruction Decoder

This block takes one 32-bit instruction word and decides whether it is a valid instruction from the atomic-memory opcode group. An atomic instruction here is a reserved load, a conditional store, or one of nine read-modify-write operations. For a valid word the block reports the operation class, an arithmetic sub-operation code for the read-modify-write unit, the two memory-ordering flags, the three register indices and the access size. The decoder is purely combinational and sits beside the main decoder in an issue stage.

A word whose major opcode is outside the atomic group leaves every output low, so the main decoder handles it. A word inside the group that breaks any encoding rule raises the illegal flag and forces every other output low. The rules cover the function code, the fixed-zero bit, the size code and the source-2 slot of a reserved load. The parameter `XLEN` (32 or 64) sets the native register width. It decides whether the 8-byte access size is accepted.

Top module: `atomic_insn_decoder`

## Requirements
- R1: When bits [6:0] differ from 7'b0101111, `valid_o` and `illegal_o` are 0 and every other output is 0.
- R2: With the opcode matching and the word otherwise legal, bits [31:27] select the class and sub-operation. `op_class_o` is 1 for 5'b00010 (reserved load), 2 for 5'b00011 (conditional store) and 3 for read-modify-write. `alu_op_o` is 0 for classes 1 and 2. For class 3 it is 1 for swap 00001, 2 for add 00000, 3 for xor 00100, 4 for and 01100, 5 for or 01000, 6 for signed min 10000, 7 for signed max 10100, 8 for unsigned min 11000 and 9 for unsigned max 11100.
- R3: A function code in bits [31:27] outside those eleven values gives `illegal_o`=1 and `valid_o`=0, with all other outputs 0.
- R4: Bit 14 set to 1 makes the word illegal.
- R5: Size code bits [13:12]: 2'b10 is a 4-byte access (`dword_o`=0) and 2'b11 is an 8-byte access (`dword_o`=1). 2'b11 is illegal when `XLEN`=32. 2'b00 and 2'b01 are always illegal.
- R6: A reserved load whose bits [24:20] are not all zero is illegal.
- R7: For a valid word, `acquire_o` equals bit 26 and `release_o` equals bit 25.
- R8: For a valid word, `rd_o` = bits [11:7] and `rs1_o` = bits [19:15`]`. `rs2_o` = bits [24:20] for the conditional store and read-modify-write classes, and 0 for a reserved load.
- R9: `valid_o` and `illegal_o` are never 1 together. An illegal word drives every field output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn_i | input | 32 | Instruction word under decode |
| valid_o | output | 1 | Word is a legal atomic instruction |
| illegal_o | output | 1 | Word is in the atomic opcode group but badly encoded |
| op_class_o | output | 2 | 0 none, 1 reserved load, 2 conditional store, 3 read-modify-write |
| alu_op_o | output | 4 | Read-modify-write sub-operation, 0 when not applicable |
| acquire_o | output | 1 | Acquire ordering flag |
| release_o | output | 1 | Release ordering flag |
| rd_o | output | 5 | Destination register index |
| rs1_o | output | 5 | Address register index |
| rs2_o | output | 5 | Data register index |
| dword_o | output | 1 | 1 for an 8-byte access, 0 for 4 bytes |

## Verification
The checks evaluate only when the instruction input holds no unknown bits. They assume the input settles as a whole between samples. The stimulus drives a fully defined word once per cycle, away from the sampling edge. Random words are biased toward the atomic opcode, known function codes, a clear bit 14 and the two legal size codes, so that both legal and illegal paths are exercised often. Two instances cover both register widths.

// File: rtl/atomic_insn_decoder_pkg.sv
package atomic_insn_decoder_pkg;
  localparam int          INSN_W     = 32;
  localparam int          OPC_W      = 7;
  localparam int          FUNC_W     = 5;
  localparam int          RIDX_W     = 5;
  localparam int          SIZE_W     = 2;
  localparam logic [OPC_W-1:0] OPC_ATOMIC = 7'b0101111;

  typedef enum logic [1:0] {
    CLS_NONE = 2'd0,
    CLS_LDR  = 2'd1,
    CLS_STC  = 2'd2,
    CLS_RMW  = 2'd3
  } op_class_e;

  typedef enum logic [3:0] {
    RMW_NONE = 4'd0,
    RMW_SWAP = 4'd1,
    RMW_ADD  = 4'd2,
    RMW_XOR  = 4'd3,
    RMW_AND  = 4'd4,
    RMW_OR   = 4'd5,
    RMW_SMIN = 4'd6,
    RMW_SMAX = 4'd7,
    RMW_UMIN = 4'd8,
    RMW_UMAX = 4'd9
  } rmw_op_e;

  typedef struct packed {
    logic [FUNC_W-1:0] func;
    logic              acq;
    logic              rel;
    logic [RIDX_W-1:0] src2;
    logic [RIDX_W-1:0] src1;
    logic              zero_bit;
    logic [SIZE_W-1:0] size;
    logic [RIDX_W-1:0] dst;
    logic [OPC_W-1:0]  opcode;
  } insn_fields_t;
endpackage

// File: rtl/atomic_field_split.sv
module atomic_field_split
  import atomic_insn_decoder_pkg::*;
(
  input  logic [INSN_W-1:0] word_i,
  output insn_fields_t      fld_o
);
  always_comb begin
    fld_o.opcode   = word_i[6:0];
    fld_o.dst      = word_i[11:7];
    fld_o.size     = word_i[13:12];
    fld_o.zero_bit = word_i[14];
    fld_o.src1     = word_i[19:15];
    fld_o.src2     = word_i[24:20];
    fld_o.rel      = word_i[25];
    fld_o.acq      = word_i[26];
    fld_o.func     = word_i[31:27];
  end
endmodule

// File: rtl/atomic_func_decode.sv
module atomic_func_decode
  import atomic_insn_decoder_pkg::*;
(
  input  logic [FUNC_W-1:0] func_i,
  output op_class_e         cls_o,
  output rmw_op_e           rmw_o,
  output logic              known_o,
  output logic              src2_zero_o
);
  always_comb begin
    cls_o       = CLS_RMW;
    rmw_o       = RMW_NONE;
    known_o     = 1'b1;
    src2_zero_o = 1'b0;
    unique case (func_i)
      5'b00010: begin cls_o = CLS_LDR; src2_zero_o = 1'b1; end
      5'b00011: cls_o = CLS_STC;
      5'b00001: rmw_o = RMW_SWAP;
      5'b00000: rmw_o = RMW_ADD;
      5'b00100: rmw_o = RMW_XOR;
      5'b01100: rmw_o = RMW_AND;
      5'b01000: rmw_o = RMW_OR;
      5'b10000: rmw_o = RMW_SMIN;
      5'b10100: rmw_o = RMW_SMAX;
      5'b11000: rmw_o = RMW_UMIN;
      5'b11100: rmw_o = RMW_UMAX;
      default: begin
        cls_o   = CLS_NONE;
        known_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/atomic_size_check.sv
module atomic_size_check
  import atomic_insn_decoder_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [SIZE_W-1:0] size_i,
  output logic              ok_o,
  output logic              dword_o
);
  localparam int XBYTES = XLEN / 8;
  logic wide_ok;

  generate
    if (XBYTES >= 8) begin : g_wide
      assign wide_ok = 1'b1;
    end else begin : g_narrow
      assign wide_ok = 1'b0;
    end
  endgenerate

  always_comb begin
    ok_o    = 1'b0;
    dword_o = 1'b0;
    unique case (size_i)
      2'b10: ok_o = 1'b1;
      2'b11: begin
        ok_o    = wide_ok;
        dword_o = 1'b1;
      end
      default: ok_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/atomic_insn_decoder.sv
module atomic_insn_decoder
  import atomic_insn_decoder_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [31:0] insn_i,
  output logic        valid_o,
  output logic        illegal_o,
  output logic [1:0]  op_class_o,
  output logic [3:0]  alu_op_o,
  output logic        acquire_o,
  output logic        release_o,
  output logic [4:0]  rd_o,
  output logic [4:0]  rs1_o,
  output logic [4:0]  rs2_o,
  output logic        dword_o
);
  insn_fields_t fld;
  op_class_e    cls;
  rmw_op_e      rmw;
  logic         known, src2_zero, size_ok, is_dword;
  logic         in_group, enc_ok, good;

  atomic_field_split u_split (
    .word_i (insn_i),
    .fld_o  (fld)
  );

  atomic_func_decode u_func (
    .func_i      (fld.func),
    .cls_o       (cls),
    .rmw_o       (rmw),
    .known_o     (known),
    .src2_zero_o (src2_zero)
  );

  atomic_size_check #(.XLEN(XLEN)) u_size (
    .size_i  (fld.size),
    .ok_o    (size_ok),
    .dword_o (is_dword)
  );

  always_comb begin
    in_group = (fld.opcode == OPC_ATOMIC);
    enc_ok   = known && !fld.zero_bit && size_ok &&
               (!src2_zero || (fld.src2 == '0));
    good     = in_group && enc_ok;

    valid_o    = good;
    illegal_o  = in_group && !enc_ok;
    op_class_o = good ? cls : CLS_NONE;
    alu_op_o   = good ? rmw : RMW_NONE;
    acquire_o  = good && fld.acq;
    release_o  = good && fld.rel;
    rd_o       = good ? fld.dst  : '0;
    rs1_o      = good ? fld.src1 : '0;
    rs2_o      = good ? fld.src2 : '0;
    dword_o    = good && is_dword;
  end
endmodule

// File: rtl/atomic_insn_decoder_chk.sv
module atomic_insn_decoder_chk #(
  parameter int XLEN = 64
) (
  input logic [31:0] insn_i,
  input logic        valid_o,
  input logic        illegal_o,
  input logic [1:0]  op_class_o,
  input logic [3:0]  alu_op_o,
  input logic        acquire_o,
  input logic        release_o,
  input logic [4:0]  rd_o,
  input logic [4:0]  rs1_o,
  input logic [4:0]  rs2_o,
  input logic        dword_o
);
  always_comb begin
    if (!$isunknown(insn_i)) begin
      p_excl_r9: assert (!(valid_o && illegal_o));
      p_outside_r1: assert ((insn_i[6:0] == 7'b0101111) || (!valid_o && !illegal_o));
      p_quiet_r9: assert (valid_o || (op_class_o == 2'd0 && alu_op_o == 4'd0 &&
                          !acquire_o && !release_o && rd_o == 5'd0 &&
                          rs1_o == 5'd0 && rs2_o == 5'd0 && !dword_o));
      p_bit14_r4: assert (!insn_i[14] || !valid_o);
      p_ldr_src2_r6: assert (!(valid_o && op_class_o == 2'd1) || (insn_i[24:20] == 5'd0 && rs2_o == 5'd0));
      p_size_r5: assert (!valid_o || insn_i[13] == 1'b1);
      p_narrow_r5: assert (!(valid_o && dword_o) || XLEN == 64);
      p_order_r7: assert (!valid_o || (acquire_o == insn_i[26] && release_o == insn_i[25]));
      p_rmw_alu_r2: assert (!valid_o || ((op_class_o == 2'd3) == (alu_op_o != 4'd0)));
    end
  end
endmodule

bind atomic_insn_decoder atomic_insn_decoder_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/atomic_insn_decoder_bench.sv
module atomic_insn_decoder_bench;
  logic clk;
  logic rst_n;
  logic [31:0] insn;

  logic       v64, i64, a64, r64, d64;
  logic [1:0] c64;
  logic [3:0] o64;
  logic [4:0] rd64, s164, s264;
  logic       v32, i32, a32, r32, d32;
  logic [1:0] c32;
  logic [3:0] o32;
  logic [4:0] rd32, s132, s232;

  int n_run;
  int n_fail;
  bit done;

  atomic_insn_decoder #(.XLEN(64)) u_atomic_insn_decoder (
    .insn_i(insn), .valid_o(v64), .illegal_o(i64), .op_class_o(c64), .alu_op_o(o64),
    .acquire_o(a64), .release_o(r64), .rd_o(rd64), .rs1_o(s164), .rs2_o(s264), .dword_o(d64)
  );

  atomic_insn_decoder #(.XLEN(32)) u_atomic_insn_decoder_x32 (
    .insn_i(insn), .valid_o(v32), .illegal_o(i32), .op_class_o(c32), .alu_op_o(o32),
    .acquire_o(a32), .release_o(r32), .rd_o(rd32), .rs1_o(s132), .rs2_o(s232), .dword_o(d32)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Expected outputs packed as {valid, illegal, class[1:0], alu[3:0], acq, rel, rd, rs1, rs2, dword}
  function automatic logic [25:0] expect_of(input logic [31:0] w, input int xlen);
    logic [1:0] cls;
    logic [3:0] alu;
    logic known, ok;
    known = 1'b1;
    alu   = 4'd0;
    cls   = 2'd3;
    case (w[31:27])
      5'b00010: cls = 2'd1;
      5'b00011: cls = 2'd2;
      5'b00001: alu = 4'd1;
      5'b00000: alu = 4'd2;
      5'b00100: alu = 4'd3;
      5'b01100: alu = 4'd4;
      5'b01000: alu = 4'd5;
      5'b10000: alu = 4'd6;
      5'b10100: alu = 4'd7;
      5'b11000: alu = 4'd8;
      5'b11100: alu = 4'd9;
      default: known = 1'b0;
    endcase
    if (w[6:0] != 7'b0101111) return '0;
    ok = known && !w[14] && (w[13:12] == 2'b10 || (w[13:12] == 2'b11 && xlen == 64)) &&
         !(cls == 2'd1 && w[24:20] != 5'd0);
    if (!ok) return {1'b0, 1'b1, 24'd0};
    return {1'b1, 1'b0, cls, alu, w[26], w[25], w[11:7], w[19:15], w[24:20], w[12]};
  endfunction

  function automatic string tag_of(input logic [31:0] w, input int xlen);
    logic [25:0] e;
    e = expect_of(w, xlen);
    if (w[6:0] != 7'b0101111) return "R1";
    if (e[25]) return "R2/R7/R8";
    if (!(w[31:27] inside {5'b00010, 5'b00011, 5'b00001, 5'b00000, 5'b00100, 5'b01100,
                           5'b01000, 5'b10000, 5'b10100, 5'b11000, 5'b11100})) return "R3";
    if (w[14]) return "R4";
    if (w[13] != 1'b1 || (w[12] && xlen == 32)) return "R5";
    return "R6";
  endfunction

  task automatic check_both(input logic [31:0] w, input string tag);
    logic [25:0] got64, got32, exp64, exp32;
    @(posedge clk);
    insn <= w;
    @(negedge clk);
    got64 = {v64, i64, c64, o64, a64, r64, rd64, s164, s264, d64};
    got32 = {v32, i32, c32, o32, a32, r32, rd32, s132, s232, d32};
    exp64 = expect_of(w, 64);
    exp32 = expect_of(w, 32);
    n_run++;
    if (got64 !== exp64) begin
      n_fail++;
      $display("FAIL %s (%s, XLEN=64) insn=%h actual=%h expected=%h", tag, tag_of(w, 64), w, got64, exp64);
    end
    n_run++;
    if (got32 !== exp32) begin
      n_fail++;
      $display("FAIL %s (%s, XLEN=32) insn=%h actual=%h expected=%h", tag, tag_of(w, 32), w, got32, exp32);
    end
    // R9: valid and illegal never together
    n_run++;
    if ((v64 && i64) || (v32 && i32)) begin
      n_fail++;
      $display("FAIL R9 insn=%h actual v/i=%b%b %b%b expected not both set", w, v64, i64, v32, i32);
    end
  endtask

  function automatic logic [31:0] mk(input logic [4:0] f, input logic aq, input logic rl,
                                     input logic [4:0] r2, input logic [4:0] r1, input logic b14,
                                     input logic [1:0] sz, input logic [4:0] rd);
    return {f, aq, rl, r2, r1, b14, sz, rd, 7'b0101111};
  endfunction

  function automatic logic [31:0] rand_word();
    logic [31:0] w;
    logic [4:0] fl [11] = '{5'b00010, 5'b00011, 5'b00001, 5'b00000, 5'b00100, 5'b01100,
                           5'b01000, 5'b10000, 5'b10100, 5'b11000, 5'b11100};
    w = $urandom;
    if ($urandom_range(9) != 0) w[6:0] = 7'b0101111;
    if ($urandom_range(7) != 0) w[31:27] = fl[$urandom_range(10)];
    if ($urandom_range(7) != 0) w[14] = 1'b0;
    if ($urandom_range(5) != 0) w[13] = 1'b1;
    if (w[31:27] == 5'b00010 && $urandom_range(1) == 0) w[24:20] = 5'd0;
    return w;
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : stim
    int seed_ret;
    n_run = 0;
    n_fail = 0;
    done = 1'b0;
    rst_n = 1'b0;
    insn = 32'h0000_0013;
    seed_ret = $urandom(32'd20240611);
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R1: non-atomic word (initial state) and opcode one bit off
    check_both(32'h0000_0013, "R1");
    check_both(mk(5'b00001, 1, 1, 5'd3, 5'd4, 0, 2'b10, 5'd5) ^ 32'h1, "R1");
    // R2: every function code, word size
    check_both(mk(5'b00010, 0, 0, 5'd0, 5'd9, 0, 2'b10, 5'd1), "R2");
    check_both(mk(5'b00011, 0, 0, 5'd7, 5'd9, 0, 2'b10, 5'd1), "R2");
    for (int k = 0; k < 32; k++)
      check_both(mk(k[4:0], k[0], k[1], 5'd17, 5'd30, 0, 2'b10, 5'd31), "R2/R3");
    // R3: unknown function code
    check_both(mk(5'b11111, 1, 0, 5'd2, 5'd2, 0, 2'b10, 5'd2), "R3");
    // R4: bit 14 set on a legal op
    check_both(mk(5'b00000, 0, 0, 5'd2, 5'd2, 1, 2'b10, 5'd2), "R4");
    // R5: each size code, both widths
    for (int s = 0; s < 4; s++)
      check_both(mk(5'b11100, 0, 1, 5'd6, 5'd7, 0, s[1:0], 5'd8), "R5");
    // R6: reserved load with nonzero src2 slot, and with zero
    check_both(mk(5'b00010, 1, 1, 5'd1, 5'd3, 0, 2'b11, 5'd4), "R6");
    check_both(mk(5'b00010, 1, 1, 5'd0, 5'd3, 0, 2'b11, 5'd4), "R6");
    // R7: all four ordering combinations
    for (int q = 0; q < 4; q++)
      check_both(mk(5'b01000, q[1], q[0], 5'd11, 5'd12, 0, 2'b10, 5'd13), "R7");
    // R8: register fields at extremes
    check_both(mk(5'b00011, 0, 0, 5'd31, 5'd0, 0, 2'b11, 5'd31), "R8");
    check_both(mk(5'b10000, 0, 0, 5'd0, 5'd31, 0, 2'b10, 5'd0), "R8");

    for (int n = 0; n < 3000; n++)
      check_both(rand_word(), "random");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule